// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a clocked system read and write a 32K x 8 asynchronous static RAM. A master presents a request with a 15-bit address, a read/write flag and, for writes, one byte of data. The controller then drives the memory's three active-low strobes (chip enable, output enable, write enable), its address bus, and a tri-state data bus split into separate in, out and drive-enable signals. When the access completes it answers with a one-cycle acknowledge, which carries the read byte for a read.

Every analog timing figure of the memory is turned into a whole number of clock cycles by rounding up the ratio of nanoseconds to the clock period. Two parameters set the conversion: the clock period in nanoseconds and a speed grade, which is 0 for the 25 ns part and 1 for the 45 ns part. Reads hold chip enable and output enable low for the access count and sample the bus on the edge that ends it. Writes hold chip enable and write enable low together for the write-window count and release both on the same edge. A write never drives the bus until the memory has had its output-float time after the previous read. The master keeps its request high until it sees acknowledge, and drops it in the acknowledge cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low, and after it until a request is accepted, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and ack is 0; requests present during reset start no access.
- R2: A read holds mem_ce_n=0 and mem_oe_n=0 with mem_we_n=1. It lasts NA = ceil(max(address, chip-enable, output-enable access)/period) cycles, where access is 25 ns for grade 0 and 45 ns for grade 1. rdata is the bus value sampled on the edge that ends this window.
- R3: A write holds mem_ce_n=0 and mem_we_n=0 together, with mem_oe_n=1, for exactly NW = ceil(max(write pulse, data setup, address-to-end)/period) cycles. Those figures are 15/12/15 ns for grade 0 and 25/20/25 ns for grade 1. Both strobes rise on the same edge, and mem_addr and mem_dq_out do not change during the window.
- R4: mem_dq_oe is 1 for every cycle of the write window and falls on the edge where the strobes rise; it is 0 at all other times.
- R5: After mem_oe_n rises at the end of a read, mem_dq_oe is not raised for at least NF = ceil(float/period) cycles, where float is 12 ns for grade 0 and 20 ns for grade 1. A write that is accepted earlier waits, with all strobes high.
- R6: Two successive falls of mem_ce_n are at least ceil(cycle/period) cycles apart, where cycle is 25 ns for grade 0 and 45 ns for grade 1.
- R7: ack is high for exactly one cycle per access. A request that is still high during the ack cycle is ignored, and a new request is accepted only from the cycle after it.
- R8: Measured from the accepting edge, ack rises NA + RR cycles later for a read and FW + NW + RW cycles later for a write. RR = max(0, NC-NA-2) and RW = max(0, NC-NW-2), with NC the cycle count of R6. FW is the float wait of R5 still owed at acceptance.
- R9: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with ack of a read |
| mem_ce_n | output | 1 | Chip enable to memory, active low |
| mem_oe_n | output | 1 | Output enable to memory, active low |
| mem_we_n | output | 1 | Write enable to memory, active low |
| mem_addr | output | 15 | Address bus to memory |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Data bus as seen from memory |

## Verification
The hardest situation to reach is a write that has to stall for the bus to float after a read. At a 10 ns clock the float time has already passed by the time a new request can be accepted, so the stall never occurs. The bench therefore runs a 5 ns clock with the slow grade. Reads then end with four float cycles owed, and random streams issue writes right after reads with zero to two idle cycles, so the stall takes each of its lengths. The memory model in the bench returns inverted data until the full access time has passed, so an early sample shows up as a data error.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and the nanosecond-to-cycle conversion
// used by the SRAM timing controller. Assumes positive clock periods.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WWAIT = 3'd2,
        ST_WRITE = 3'd3,
        ST_RECOV = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    // Round a time in ns up to whole clock cycles.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pick the figure for the speed grade (0 = fast, 1 = slow).
    function automatic int by_grade(input int grade, input int fast_ns, input int slow_ns);
        return (grade == 0) ? fast_ns : slow_ns;
    endfunction

    // Cycles of recovery needed after an access of busy cycles so that the
    // next start is at least cyc cycles after this one (two cycles of
    // ack/idle always separate them).
    function automatic int recovery(input int cyc, input int busy);
        return (cyc > busy + 2) ? (cyc - busy - 2) : 0;
    endfunction

endpackage

// File: rtl/sram_float_guard.sv
`timescale 1ns/1ps
// Module: sram_float_guard
// Counts the memory's output-float time after a read releases output
// enable, and reports when the data bus may be driven again.
// Assumes rd_release pulses on the clock edge where output enable rises.
module sram_float_guard #(
    parameter int FLOAT_CYC = 2,
    parameter int CNT_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_release,
    output logic bus_free
);
    localparam logic [CNT_W-1:0] LOAD_VAL =
        (FLOAT_CYC > 0) ? CNT_W'(FLOAT_CYC - 1) : '0;

    logic [CNT_W-1:0] flt_cnt;

    // Load the float window on read release, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_cnt <= '0;
        end else if (rd_release) begin
            flt_cnt <= LOAD_VAL;
        end else if (flt_cnt != '0) begin
            flt_cnt <= flt_cnt - 1'b1;
        end
    end

    assign bus_free = (flt_cnt == '0);

endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
// Module: sram_datapath
// Holds the address and write byte of the accepted request for the whole
// access, and captures the read byte when the sequencer says so.
// Assumes load and capture never occur in the same cycle.
module sram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Latch request address and write byte when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    // Sample the memory bus at the end of the read access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end

    assign mem_addr = addr_q;
    assign bus_out  = wdata_q;
    assign rdata    = rdata_q;

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));

    // R3
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(bus_out));

endmodule

// File: rtl/sram_sequencer.sv
`timescale 1ns/1ps
// Module: sram_sequencer
// Cycle sequencer for the memory strobes: accepts a request in idle,
// times the read access or the write window, adds recovery to meet the
// cycle minimum and pulses ack for one cycle. Strobes are registered so
// they change only on clock edges. Assumes counts ACC_CYC, WE_CYC >= 1.
module sram_sequencer
    import sram_ctrl_pkg::*;
#(
    parameter int ACC_CYC  = 3,
    parameter int WE_CYC   = 2,
    parameter int RREC_CYC = 0,
    parameter int WREC_CYC = 0,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_write,
    input  logic bus_free,
    output logic load,
    output logic capture,
    output logic rd_release,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe,
    output logic ack
);
    localparam logic [CNT_W-1:0] ACC_LOAD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RREC_LOAD = (RREC_CYC > 0) ? CNT_W'(RREC_CYC - 1) : '0;
    localparam logic [CNT_W-1:0] WREC_LOAD = (WREC_CYC > 0) ? CNT_W'(WREC_CYC - 1) : '0;

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero   = (cnt == '0);
    assign load       = (state == ST_IDLE) && req;
    assign capture    = (state == ST_READ) && cnt_zero;
    assign rd_release = capture;

    // Main state register: strobes, counter, ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            ack   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        if (!req_write) begin
                            ce_n  <= 1'b0;
                            oe_n  <= 1'b0;
                            cnt   <= ACC_LOAD;
                            state <= ST_READ;
                        end else if (bus_free) begin
                            ce_n  <= 1'b0;
                            we_n  <= 1'b0;
                            dq_oe <= 1'b1;
                            cnt   <= WE_LOAD;
                            state <= ST_WRITE;
                        end else begin
                            state <= ST_WWAIT;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_zero) begin
                        ce_n <= 1'b1;
                        oe_n <= 1'b1;
                        if (RREC_CYC > 0) begin
                            cnt   <= RREC_LOAD;
                            state <= ST_RECOV;
                        end else begin
                            ack   <= 1'b1;
                            state <= ST_DONE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WWAIT: begin
                    if (bus_free) begin
                        ce_n  <= 1'b0;
                        we_n  <= 1'b0;
                        dq_oe <= 1'b1;
                        cnt   <= WE_LOAD;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (cnt_zero) begin
                        ce_n  <= 1'b1;
                        we_n  <= 1'b1;
                        dq_oe <= 1'b0;
                        if (WREC_CYC > 0) begin
                            cnt   <= WREC_LOAD;
                            state <= ST_RECOV;
                        end else begin
                            ack   <= 1'b1;
                            state <= ST_DONE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RECOV: begin
                    if (cnt_zero) begin
                        ack   <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DONE: begin
                    ack   <= 1'b0;
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R3
    wr_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n));

    // R4
    wr_bus_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    // R4
    bus_only_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n);

    // R3
    wr_end_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> $rose(ce_n));

    // R2
    rd_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && we_n));

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    ack_idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ce_n && oe_n && we_n));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
// Module: sram_ctrl (top)
// Synchronous controller for a 32K x 8 asynchronous SRAM. Converts the
// memory's timing figures for the chosen speed grade into cycle counts
// and wires the sequencer, float guard and datapath together.
// Assumes the master holds req until ack and drops it in the ack cycle.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Timing figures in ns for the selected grade.
    localparam int T_ACC_NS = imax(imax(by_grade(SPEED_GRADE, 25, 45),
                                        by_grade(SPEED_GRADE, 25, 45)),
                                   by_grade(SPEED_GRADE, 13, 25));
    localparam int T_WIN_NS = imax(imax(by_grade(SPEED_GRADE, 15, 25),
                                        by_grade(SPEED_GRADE, 12, 20)),
                                   by_grade(SPEED_GRADE, 15, 25));
    localparam int T_RC_NS  = by_grade(SPEED_GRADE, 25, 45);
    localparam int T_WC_NS  = by_grade(SPEED_GRADE, 25, 45);
    localparam int T_FLT_NS = by_grade(SPEED_GRADE, 12, 20);

    // Cycle counts derived from the clock period.
    localparam int N_ACC  = imax(1, ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS));
    localparam int N_WE   = imax(1, ns_to_cycles(T_WIN_NS, CLK_PERIOD_NS));
    localparam int N_RC   = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int N_WC   = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int N_FLT  = ns_to_cycles(T_FLT_NS, CLK_PERIOD_NS);
    localparam int N_RREC = recovery(N_RC, N_ACC);
    localparam int N_WREC = recovery(N_WC, N_WE);
    localparam int N_MAX  = imax(imax(N_ACC, N_WE), imax(imax(N_RREC, N_WREC), N_FLT));
    localparam int CNT_W  = $clog2(N_MAX + 1) + 1;

    logic load;
    logic capture;
    logic rd_release;
    logic bus_free;

    sram_sequencer #(
        .ACC_CYC  (N_ACC),
        .WE_CYC   (N_WE),
        .RREC_CYC (N_RREC),
        .WREC_CYC (N_WREC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_write  (req_write),
        .bus_free   (bus_free),
        .load       (load),
        .capture    (capture),
        .rd_release (rd_release),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_oe      (mem_dq_oe),
        .ack        (ack)
    );

    sram_float_guard #(
        .FLOAT_CYC (N_FLT),
        .CNT_W     (CNT_W)
    ) u_float (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_release (rd_release),
        .bus_free   (bus_free)
    );

    sram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .capture  (capture),
        .ce_n     (mem_ce_n),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .bus_in   (mem_dq_in),
        .mem_addr (mem_addr),
        .bus_out  (mem_dq_out),
        .rdata    (rdata)
    );

    // R5
    drive_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(bus_free));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
// Bench for sram_ctrl: slow grade at a 5 ns clock, with a cycle-level
// memory model that also checks the strobe timing.
module sram_ctrl_test;
    localparam int CLK_NS = 5;
    localparam int GRADE  = 1;

    function automatic int cdiv(input int t, input int p);
        return (t + p - 1) / p;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_ACC  = cdiv(45, CLK_NS);
    localparam int B_WE   = cdiv(mx(mx(25, 20), 25), CLK_NS);
    localparam int B_CYC  = cdiv(45, CLK_NS);
    localparam int B_FLT  = cdiv(20, CLK_NS);
    localparam int B_RREC = mx(0, B_CYC - B_ACC - 2);
    localparam int B_WREC = mx(0, B_CYC - B_WE - 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    sram_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, ncyc);
        end
    endtask

    // Memory model and timing monitor, evaluated mid-cycle.
    logic [7:0] model [logic [14:0]];
    logic [7:0] shadow [logic [14:0]];
    int  rd_len = 0, wr_len = 0, oe_hi = 1000, last_fall = -1000;
    bit  prev_ce_n = 1'b1;
    logic [14:0] w_addr;
    logic [7:0]  w_data;

    function automatic logic [7:0] model_rd(input logic [14:0] a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            // R6 spacing of chip-enable falls
            if (prev_ce_n && !mem_ce_n) begin
                check((ncyc - last_fall) >= B_CYC, "R6 ce fall spacing", ncyc - last_fall, B_CYC);
                last_fall = ncyc;
            end
            prev_ce_n = mem_ce_n;
            // R5 bus drive only after float time
            if (mem_oe_n) oe_hi = (oe_hi < 1000) ? oe_hi + 1 : oe_hi; else oe_hi = 0;
            if (mem_dq_oe && wr_len == 0)
                check(oe_hi >= B_FLT + 1, "R5 drive after float", oe_hi - 1, B_FLT);
            // R3/R4 write window
            if (!mem_ce_n && !mem_we_n) begin
                if (wr_len > 0) begin
                    if (mem_addr != w_addr || mem_dq_out != w_data)
                        check(1'b0, "R3 addr/data stable in window", int'(mem_dq_out), int'(w_data));
                end
                if (!mem_dq_oe) check(1'b0, "R4 bus driven in window", 0, 1);
                if (!mem_oe_n) check(1'b0, "R3 oe high in write", 0, 1);
                w_addr = mem_addr;
                w_data = mem_dq_out;
                wr_len++;
            end else if (wr_len > 0) begin
                model[w_addr] = w_data;
                check(wr_len == B_WE, "R3 write window length", wr_len, B_WE);
                check(mem_ce_n && mem_we_n, "R3 strobes rise together", int'(mem_ce_n), int'(mem_we_n));
                check(!mem_dq_oe, "R4 bus released at write end", int'(mem_dq_oe), 0);
                wr_len = 0;
            end
            // Read drive: correct data only after full access time.
            if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_len++; else rd_len = 0;
            mem_dq_in = (rd_len >= B_ACC) ? model_rd(mem_addr) : ~model_rd(mem_addr);
        end
    end

    bit prev_was_read = 1'b0;

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d, input int gap);
        int lat;
        int expl;
        int flt_wait;
        logic [7:0] got;
        repeat (gap) @(negedge clk);
        flt_wait = prev_was_read ? mx(0, B_FLT - (B_RREC + 2 + gap)) : 0;
        expl = wr ? (flt_wait + B_WE + B_WREC + 1) : (B_ACC + B_RREC + 1);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (ack || lat > 200) break;
        end
        got = rdata;
        req = 1'b0;
        check(ack, "R7 ack arrives", int'(ack), 1);
        check(lat == expl, wr ? "R8 write ack latency" : "R8 read ack latency", lat, expl);
        if (wr) shadow[a] = d;
        else check(got == (shadow.exists(a) ? shadow[a] : 8'h00), "R9 read data", int'(got),
                   int'(shadow.exists(a) ? shadow[a] : 8'h00));
        if (!wr) check(1'b1, "R2 read completed", 0, 0);
        @(negedge clk);
        check(!ack, "R7 ack one cycle", int'(ack), 0);
        prev_was_read = !wr;
    endtask

    // Watchdog
    initial begin
        wait (ncyc > 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [14:0] pool [0:11];

    initial begin
        void'($urandom(32'd4242));
        req = 1'b1; req_write = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state, request ignored during reset
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", int'(mem_ce_n), 1);
        check(!mem_dq_oe && !ack, "R1 bus off, no ack in reset", int'(mem_dq_oe), 0);
        req = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack,
              "R1 idle after reset", int'(mem_ce_n), 1);

        for (int i = 0; i < 12; i++) pool[i] = 15'($urandom);
        pool[0] = 15'h0000;
        pool[1] = 15'h7FFF;

        // Directed: unwritten read, boundary addresses, write then read.
        do_op(1'b0, 15'h7FFF, 8'h00, 0);
        do_op(1'b1, 15'h0000, 8'hA5, 0);
        do_op(1'b1, 15'h7FFF, 8'h3C, 0);
        do_op(1'b0, 15'h0000, 8'h00, 0);
        do_op(1'b1, 15'h0000, 8'h5A, 0);   // R5 write right after read: float wait
        do_op(1'b0, 15'h7FFF, 8'h00, 1);
        do_op(1'b1, 15'h1234, 8'hFF, 1);   // R5 shorter wait
        do_op(1'b0, 15'h0000, 8'h00, 2);

        // R7 request held through the ack cycle must be ignored.
        req = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
        begin
            int n = 0;
            forever begin @(negedge clk); n++; if (ack || n > 200) break; end
        end
        @(negedge clk);
        req = 1'b0;
        check(!ack, "R7 ack one cycle (held req)", int'(ack), 0);
        for (int k = 0; k < B_CYC + 3; k++) begin
            @(negedge clk);
            if (!mem_ce_n || ack) check(1'b0, "R7 held req ignored", int'(mem_ce_n), 1);
        end
        check(mem_ce_n, "R7 no access from held req", int'(mem_ce_n), 1);
        prev_was_read = 1'b0;

        // Random mix.
        for (int i = 0; i < 300; i++) begin
            bit wr = $urandom_range(0, 1) == 1;
            do_op(wr, pool[$urandom_range(0, 11)], 8'($urandom), $urandom_range(0, 2));
        end
        // Final readback of the pool.
        for (int i = 0; i < 12; i++) do_op(1'b0, pool[i], 8'h00, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule